// File: doc/BRIEF.md
# Four-Tap Distributed-Arithmetic Dot Product Unit

This unit forms the dot product of four signed coefficients with four signed samples without a multiplier. A start strobe copies the four samples into a register table that holds every subset sum of them, and copies the four coefficients into a holding register. The unit then steps through the coefficient bits, least significant first, one bit position per clock. The four coefficient bits at that position form a 4-bit address into the table. The selected subset sum is folded into a carry-save accumulator that shifts right by one place per step. Because the coefficients are two's complement, the entry picked by the top bit position carries negative weight. That entry is inverted bit by bit on its way into the accumulator, and the missing +1 enters as the carry-in of the final adder.

The accumulator keeps its words in offset form. Every operand is biased by half the table range, so the carry-save words never wrap. The known total bias is removed by a constant added in the final adder. The bits shifted out below the binary point are collected as the low part of the result. The result is therefore exact at the full width of sample width plus coefficient width plus two. A one-cycle done pulse marks a new result, and the result is held until the next pulse. A start that arrives while a computation is under way is ignored.

Top module: `dainp_engine`

## Requirements
- R1: While rst_ni is low, done_o is 0 and result_o is all zeros.
- R2: After an accepted start, result_o equals the exact signed sum of wgt_i[k]·smp_i[k] over k = 0..3, as sampled at the start edge. Both operands are two's complement, with coefficient k in wgt_i[k*CW+CW-1 : k*CW] and sample k in smp_i[k*XW+XW-1 : k*XW]. result_o is two's complement, XW+CW+2 bits wide.
- R3: The top coefficient bit carries weight −2^(CW−1). When all four coefficients are −2^(CW−1), the result is −2^(CW−1) times the sum of the samples, including when every sample is most negative.
- R4: done_o rises exactly CW+1 clock edges after the edge that accepts start, and stays high for one cycle only.
- R5: A start_i pulse is ignored while a computation is in progress. It neither shortens nor restarts the computation, and it yields no extra done pulse.
- R6: wgt_i and smp_i are sampled only at the accepted start edge. Changing them during the computation does not change the result.
- R7: result_o holds its value in every cycle in which done_o is low.
- R8: Coefficient bit l of tap k addresses table bit k. A coefficient set that is zero except for a single bit l in tap k yields smp_k·2^l, and yields −smp_k·2^(CW−1) when l = CW−1. All-zero coefficients yield 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | start strobe; captures coefficients and samples |
| wgt_i | input | 4*CW | four two's-complement coefficients, tap 0 in the low bits |
| smp_i | input | 4*XW | four two's-complement samples, tap 0 in the low bits |
| result_o | output | XW+CW+2 | two's-complement dot product |
| done_o | output | 1 | one-cycle pulse when result_o is updated |

## Verification
The bench runs a full sweep of tap 0's coefficient through all 256 codes, with fixed non-zero neighbours. This separates errors in the low bit slices from errors in the sign slice. One-hot coefficients at every tap and bit position show whether each coefficient bit reaches the right table address bit, and whether only the top position is negated. Extreme-value corners test the ones-complement-plus-carry-in path and the full output width, where a missing carry or a truncated low part would show. Pseudo-random vectors, some with inputs scrambled during the run or with a second start inside the run, separate the input-capture behaviour and the busy-time start handling from the arithmetic.

// File: rtl/dainp_pkg.sv
package dainp_pkg;
  localparam int unsigned NTAP  = 4;
  localparam int unsigned NADDR = 1 << NTAP;
endpackage

// File: rtl/dainp_ctrl.sv
module dainp_ctrl #(
  parameter int unsigned CW  = 8,
  localparam int unsigned SW = (CW > 1) ? $clog2(CW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          go_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [SW-1:0] slice_o,
  output logic          first_o,
  output logic          last_o
);
  logic          busy_q, fin_q;
  logic [SW-1:0] cnt_q;

  assign go_o    = start_i & ~busy_q & ~fin_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == SW'(CW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fin_q <= busy_q & last_o;
      if (go_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign fin_o   = fin_q;
  assign slice_o = cnt_q;
endmodule

// File: rtl/dainp_table.sv
module dainp_table
  import dainp_pkg::*;
#(
  parameter int unsigned XW = 8,
  localparam int unsigned TW = XW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [NTAP*XW-1:0]     smp_i,
  input  logic [NTAP-1:0]        addr_i,
  input  logic                   neg_i,
  output logic [TW-1:0]          op_o
);
  logic [TW-1:0] ext  [NTAP];
  logic [TW-1:0] tab_q [1:NADDR-1];
  logic [TW-1:0] raw;

  for (genvar k = 0; k < NTAP; k++) begin : g_ext
    assign ext[k] = {{2{smp_i[k*XW+XW-1]}}, smp_i[k*XW +: XW]};
  end

  for (genvar a = 1; a < NADDR; a++) begin : g_ent
    logic [TW-1:0] sum_d;
    assign sum_d = (((a >> 0) & 1) != 0 ? ext[0] : '0)
                 + (((a >> 1) & 1) != 0 ? ext[1] : '0)
                 + (((a >> 2) & 1) != 0 ? ext[2] : '0)
                 + (((a >> 3) & 1) != 0 ? ext[3] : '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tab_q[a] <= '0;
      else if (load_i) tab_q[a] <= sum_d;
    end
  end

  always_comb begin
    raw = '0;
    for (int a = 1; a < int'(NADDR); a++)
      if (addr_i == NTAP'(a)) raw = tab_q[a];
  end

  // ones complement on sign slice, then MSB flip to offset-binary form
  assign op_o = {~(raw[TW-1] ^ neg_i), raw[TW-2:0] ^ {(TW-1){neg_i}}};
endmodule

// File: rtl/dainp_csa_acc.sv
module dainp_csa_acc #(
  parameter int unsigned TW = 10,
  parameter int unsigned CW = 8,
  localparam int unsigned AW = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [TW-1:0] op_i,
  output logic [AW-1:0] sum_o,
  output logic [AW-1:0] car_o,
  output logic [CW-2:0] low_o
);
  logic [AW-1:0] s_q, c_q, a, b, p, u, maj;
  logic [CW-2:0] low_q;
  logic [CW-1:0] low_sh;

  assign a   = clr_i ? '0 : (s_q >> 1);
  assign b   = clr_i ? '0 : (c_q >> 1);
  assign p   = {1'b0, op_i};
  assign u   = a ^ b ^ p;
  assign maj = (a & b) | (a & p) | (b & p);
  assign low_sh = {s_q[0], low_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= '0;
      c_q   <= '0;
      low_q <= '0;
    end else if (en_i) begin
      s_q <= u;
      c_q <= {maj[AW-2:0], 1'b0};
      // carry word LSB is always zero, so s_q[0] is the exact bit leaving
      if (!clr_i) low_q <= low_sh[CW-1:1];
    end
  end

  assign sum_o = s_q;
  assign car_o = c_q;
  assign low_o = low_q;
endmodule

// File: rtl/dainp_engine.sv
module dainp_engine
  import dainp_pkg::*;
#(
  parameter int unsigned XW = 8,
  parameter int unsigned CW = 8,
  localparam int unsigned TW = XW + 2,
  localparam int unsigned AW = TW + 1,
  localparam int unsigned RW = XW + CW + 2,
  localparam int unsigned SW = (CW > 1) ? $clog2(CW) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NTAP*CW-1:0]   wgt_i,
  input  logic [NTAP*XW-1:0]   smp_i,
  output logic [RW-1:0]        result_o,
  output logic                 done_o
);
  localparam logic [RW-1:0] BIAS = RW'(1) << (TW - 1);
  localparam logic [RW-1:0] FIX  = BIAS - (BIAS << CW);

  logic          go, busy, fin, first, last;
  logic [SW-1:0] slice;
  logic [NTAP*CW-1:0] wgt_q;
  logic [NTAP-1:0]    addr;
  logic [TW-1:0]      op;
  logic [AW-1:0]      s_w, c_w;
  logic [CW-2:0]      low;
  logic [RW-1:0]      hi_sum, total, res_d;
  logic               done_q;
  logic [RW-1:0]      res_q;

  dainp_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .go_o(go), .busy_o(busy), .fin_o(fin),
    .slice_o(slice), .first_o(first), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  wgt_q <= '0;
    else if (go)  wgt_q <= wgt_i;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_addr
    assign addr[k] = wgt_q[k*CW + int'(slice)];
  end

  dainp_table #(.XW(XW)) u_tab (
    .clk_i, .rst_ni, .load_i(go), .smp_i,
    .addr_i(addr), .neg_i(last), .op_o(op)
  );

  dainp_csa_acc #(.TW(TW), .CW(CW)) u_acc (
    .clk_i, .rst_ni, .en_i(busy), .clr_i(first), .op_i(op),
    .sum_o(s_w), .car_o(c_w), .low_o(low)
  );

  // final adder: carry-in one completes the sign-slice negation
  assign hi_sum = {{(CW-1){1'b0}}, s_w} + {{(CW-1){1'b0}}, c_w} + RW'(1);
  assign total  = (hi_sum << (CW - 1)) | {{(RW-CW+1){1'b0}}, low};
  assign res_d  = total + FIX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) res_q <= res_d;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dainp_chk.sv
module dainp_chk #(
  parameter int unsigned CW = 8,
  parameter int unsigned RW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_i,
  input logic          fin_i,
  input logic          done_i,
  input logic [RW-1:0] result_i
);
  logic        run_q;
  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      lat_q <= '0;
    end else if (start_i && !busy_i && !fin_i) begin
      run_q <= 1'b1;
      lat_q <= '0;
    end else if (done_i) begin
      run_q <= 1'b0;
    end else if (run_q && lat_q != 16'hffff) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (done_i == 1'b0 && result_i == '0);
  end

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (run_q && lat_q == 16'(CW + 1)));
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  a_r5_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !done_i);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));
endmodule

bind dainp_engine dainp_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy),
  .fin_i(fin), .done_i(done_o), .result_i(result_o)
);

// File: tb/sim_dainp_engine.sv
`timescale 1ns/1ps
module sim_dainp_engine;
  localparam int XW = 8;
  localparam int CW = 8;
  localparam int RW = XW + CW + 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start = 1'b0;
  logic [4*CW-1:0] wgt = '0;
  logic [4*XW-1:0] smp = '0;
  logic [RW-1:0]   result;
  logic            done;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] rng = 32'h1357_9bdf;

  always #5 clk = ~clk;

  dainp_engine #(.XW(XW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .wgt_i(wgt), .smp_i(smp), .result_o(result), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] t = v;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic longint dot(input logic [4*CW-1:0] w, input logic [4*XW-1:0] x);
    longint acc = 0;
    for (int k = 0; k < 4; k++)
      acc += longint'($signed(w[k*CW +: CW])) * longint'($signed(x[k*XW +: XW]));
    return acc;
  endfunction

  // mode: 0 plain, 1 scramble inputs during run (R6), 2 second start during run (R5)
  task automatic run_vec(input logic [4*CW-1:0] w, input logic [4*XW-1:0] x,
                         input int mode, input string req);
    int n;
    int extra;
    longint exp;
    exp = dot(w, x);
    @(negedge clk);
    wgt = w; smp = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode == 1) begin wgt = ~w; smp = ~x; end
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      start = (mode == 2 && n == 3);
    end
    start = 1'b0;
    chk(n == CW + 2, "R4 latency", n, CW + 2);
    chk($signed(result) == exp, req, longint'($signed(result)), exp);
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse width", done, 0);
    extra = 0;
    for (int i = 0; i < CW + 3; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk($signed(result) == exp, "R7 hold", longint'($signed(result)), exp);
    if (mode == 2) chk(extra == 0, "R5 start while busy", extra, 0);
    wgt = '0; smp = '0;
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [4*CW-1:0] w;
    logic [4*XW-1:0] x;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(result == '0, "R1 reset result", longint'(result), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 sign slice corners
    run_vec({4{8'h80}}, {4{8'h80}}, 0, "R3 all most negative");
    run_vec({4{8'h80}}, {4{8'h7f}}, 0, "R3 neg weights pos samples");
    run_vec({4{8'h7f}}, {4{8'h80}}, 0, "R2 max weights neg samples");
    run_vec({4{8'hff}}, {8'h01, 8'hff, 8'h40, 8'hc0}, 0, "R3 minus one weights");
    // R8 zero weights and one-hot addressing
    run_vec('0, {8'h5a, 8'h81, 8'h7f, 8'h33}, 0, "R8 zero weights");
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < CW; l++) begin
        w = '0;
        w[k*CW + l] = 1'b1;
        run_vec(w, {8'h13, 8'hb7, 8'h65, 8'h9c}, 0, "R8 one-hot bit");
      end
    // R2 full sweep of tap 0 coefficient
    for (int v = 0; v < 256; v++)
      run_vec({8'h35, 8'hc9, 8'h7e, 8'(v)}, {8'h81, 8'h2d, 8'hb3, 8'h6f}, 0, "R2 tap0 sweep");
    // R2 pseudo-random, with R6 scramble and R5 restart variants
    for (int i = 0; i < 150; i++) begin
      rng = nxt(rng); w = rng;
      rng = nxt(rng); x = rng;
      run_vec(w, x, (i % 5 == 1) ? 1 : ((i % 5 == 3) ? 2 : 0),
              (i % 5 == 1) ? "R6 inputs changed mid-run" :
              ((i % 5 == 3) ? "R5 restart ignored" : "R2 random"));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule